// File: doc/BRIEF.md
# Shared RAM Bus Ownership Master

This block lets an on-chip agent borrow an external processor/RAM bus that normally belongs to a host. Internal requesters push read and write operations into a small in-order queue. Each operation carries a 16-bit address and, for writes, a 16-bit data word. When work is pending, the block lowers an active-low bus request. It waits until the host lowers its active-low grant, then lowers an active-low acknowledge to mark the window in which it owns the bus. Inside that window it performs the queued transfers on the shared address bus and the bidirectional data bus. It pulses an active-low write strobe for each store and an active-low output enable for each load.

Every access has a fixed length. Each one has a setup cycle, a strobe phase and a hold cycle. Read data comes back on an internal one-cycle result pulse. When the queue runs dry, or when the host withdraws its grant, the access in flight is allowed to finish. Then request and acknowledge are released together, and the buses float. The incoming grant passes through a configurable synchronizer.

Top module: `shram_bus_master`

## Requirements
- R1: While reset is held, and directly after it, bus_req_n, bus_ack_n, ram_we_n and ram_oe_n are 1, rd_valid is 0, req_ready is 1 and neither external bus is driven.
- R2: An operation is accepted on a clock where req_valid and req_ready are both 1. Up to DEPTH operations may wait. req_ready is 0 while DEPTH operations are pending, and operations execute in acceptance order.
- R3: bus_req_n goes to 0 only when operations are pending and the synchronized grant is seen inactive (1). It stays 0 until ownership ends. bus_ack_n is 0 only while bus_req_n is 0, and it never falls without a grant.
- R4: ram_we_n and ram_oe_n go to 0 only while bus_ack_n is 0.
- R5: ram_we_n and ram_oe_n are never 0 together. An access lasts ACC_CYC cycles: one setup cycle, ACC_CYC-2 strobe cycles, and one hold cycle. A write uses ram_we_n and a read uses ram_oe_n.
- R6: The address is driven, and held stable, from the setup cycle through the hold cycle, so it is valid one cycle before the strobe falls. Neither bus is driven while bus_ack_n is 1, and both float for at least one cycle before bus_ack_n rises.
- R7: For every read, rd_valid pulses for one cycle. rd_data then holds the word present on ram_data in the last strobe cycle, and results come back in queue order.
- R8: After the last pending transfer completes, bus_req_n and bus_ack_n rise on the same clock edge.
- R9: If the grant is withdrawn while the bus is owned, the access in flight completes with its full strobe length. No new access starts, the bus is released, and the remaining operations are requested again.
- R10: The grant reaches the controller through GNT_SYNC flops. bus_ack_n falls exactly GNT_SYNC+1 clock edges after bus_gnt_n falls while a request is outstanding.
- R11: During a write, ram_data carries the queued data word for the whole access, so the external RAM ends up with the last value written to each address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation offered to the queue |
| req_ready | output | 1 | Queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Operation address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DW | Read result |
| bus_req_n | output | 1 | Active-low bus request to the host |
| bus_gnt_n | input | 1 | Active-low bus grant from the host |
| bus_ack_n | output | 1 | Active-low ownership acknowledge |
| ram_addr | output | AW | External address bus, floats when not driven |
| ram_data | inout | DW | External bidirectional data bus |
| ram_we_n | output | 1 | Active-low RAM write strobe |
| ram_oe_n | output | 1 | Active-low RAM output enable |

## Verification
The checker enforces the following on every cycle:
- the two strobes are mutually exclusive and only active under acknowledge;
- acknowledge only occurs with a request, and both are released on the same edge;
- the bus drivers are off outside the ownership window and for one cycle before its end;
- the address is set up one cycle ahead of each strobe;
- each strobe keeps its full length.

Only the bench scenarios can show the ordered content of the transfers: the address and write data of each access, the read results against a shadow memory, and the final RAM image. The same holds for the exact grant-to-acknowledge latency, back-pressure from a full queue, and recovery after a grant is pulled in the middle of an access.

// File: rtl/shram_pkg.sv
package shram_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_REQ  = 2'd1,
      OWN_HELD = 2'd2
   } own_state_e;
endpackage

// File: rtl/shram_req_fifo.sv
module shram_req_fifo #(
   parameter int W     = 33,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);
   localparam logic [PW:0] DEPTH_C = (PW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("shram_req_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW:0]   level;

   assign empty = (level == '0);
   assign full  = (level == DEPTH_C);
   assign dout  = slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop)      level <= level + 1'b1;
         else if (pop && !push) level <= level - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= din;
   end
endmodule

// File: rtl/shram_gnt_sync.sv
module shram_gnt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gnt_n_in,
   output logic gnt_n_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign gnt_n_out = gnt_n_in;
      end else begin : g_flops
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else if (STAGES == 1) chain <= gnt_n_in;
            else chain <= {chain[STAGES-2:0], gnt_n_in};
         end
         assign gnt_n_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/shram_own_ctrl.sv
module shram_own_ctrl
   import shram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic granted,
   input  logic seq_busy,
   output logic start,
   output logic bus_req_n,
   output logic bus_ack_n
);
   own_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         OWN_IDLE: if (pending && !granted) state_nx = OWN_REQ;
         OWN_REQ:  if (granted) state_nx = OWN_HELD;
         OWN_HELD: if (!seq_busy && (!pending || !granted)) state_nx = OWN_IDLE;
         default:  state_nx = OWN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= OWN_IDLE;
      else        state <= state_nx;
   end

   assign start     = (state == OWN_HELD) && !seq_busy && pending && granted;
   assign bus_req_n = (state == OWN_IDLE);
   assign bus_ack_n = (state != OWN_HELD);
endmodule

// File: rtl/shram_access_seq.sv
module shram_access_seq #(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int ACC_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_write,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          busy,
   output logic          drv_addr_en,
   output logic          drv_data_en,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic          we_n,
   output logic          oe_n,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   localparam int CW = $clog2(ACC_CYC);
   localparam logic [CW-1:0] LAST_CYC = CW'(ACC_CYC - 1);
   localparam logic [CW-1:0] STB_LAST = CW'(ACC_CYC - 2);

   logic [CW-1:0] cnt;
   logic          wr_q;
   logic          stb_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         cnt     <= '0;
         wr_q    <= start_write;
         addr_q  <= start_addr;
         wdata_q <= start_wdata;
      end else if (busy) begin
         if (cnt == LAST_CYC) busy <= 1'b0;
         else                 cnt  <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (busy && !wr_q && cnt == STB_LAST) begin
            rd_valid <= 1'b1;
            rd_data  <= bus_rdata;
         end
      end
   end

   assign stb_on      = busy && (cnt != '0) && (cnt <= STB_LAST);
   assign we_n        = !(stb_on && wr_q);
   assign oe_n        = !(stb_on && !wr_q);
   assign drv_addr_en = busy;
   assign drv_data_en = busy && wr_q;
endmodule

// File: rtl/shram_bus_master.sv
module shram_bus_master #(
   parameter int AW       = 16,
   parameter int DW       = 16,
   parameter int DEPTH    = 4,
   parameter int ACC_CYC  = 4,
   parameter int GNT_SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          bus_req_n,
   input  logic          bus_gnt_n,
   output logic          bus_ack_n,
   output logic [AW-1:0] ram_addr,
   inout  wire  [DW-1:0] ram_data,
   output logic          ram_we_n,
   output logic          ram_oe_n
);
   localparam int EW = 1 + AW + DW;

   generate
      if (DW != 16) begin : g_bad_dw
         $error("shram_bus_master: only 16-bit transfers are supported");
      end
      if (ACC_CYC < 3) begin : g_bad_acc
         $error("shram_bus_master: ACC_CYC needs setup, strobe and hold cycles");
      end
      if (GNT_SYNC < 0 || GNT_SYNC > 4) begin : g_bad_sync
         $error("shram_bus_master: GNT_SYNC must be 0..4");
      end
   endgenerate

   logic          q_push, q_empty, q_full, start;
   logic [EW-1:0] q_dout;
   logic          gnt_n_s;
   logic          seq_busy, drv_addr_en, drv_data_en;
   logic [AW-1:0] seq_addr;
   logic [DW-1:0] seq_wdata;

   assign req_ready = !q_full;
   assign q_push    = req_valid && !q_full;

   shram_req_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .din({req_write, req_addr, req_wdata}),
      .pop(start), .dout(q_dout), .empty(q_empty), .full(q_full)
   );

   shram_gnt_sync #(.STAGES(GNT_SYNC)) sync_i (
      .clk(clk), .rst_n(rst_n), .gnt_n_in(bus_gnt_n), .gnt_n_out(gnt_n_s)
   );

   shram_own_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .pending(!q_empty), .granted(!gnt_n_s), .seq_busy(seq_busy),
      .start(start), .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n)
   );

   shram_access_seq #(.AW(AW), .DW(DW), .ACC_CYC(ACC_CYC)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .start(start),
      .start_write(q_dout[EW-1]),
      .start_addr(q_dout[DW +: AW]),
      .start_wdata(q_dout[DW-1:0]),
      .bus_rdata(ram_data),
      .busy(seq_busy),
      .drv_addr_en(drv_addr_en), .drv_data_en(drv_data_en),
      .addr_q(seq_addr), .wdata_q(seq_wdata),
      .we_n(ram_we_n), .oe_n(ram_oe_n),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   assign ram_addr = drv_addr_en ? seq_addr  : {AW{1'bz}};
   assign ram_data = drv_data_en ? seq_wdata : {DW{1'bz}};
endmodule

// File: rtl/shram_bus_master_chk.sv
module shram_bus_master_chk #(
   parameter int AW      = 16,
   parameter int ACC_CYC = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req_n,
   input logic          bus_ack_n,
   input logic          ram_we_n,
   input logic          ram_oe_n,
   input logic          drv_addr_en,
   input logic          drv_data_en,
   input logic [AW-1:0] addr_q
);
   localparam int RW = $clog2(ACC_CYC) + 1;
   localparam logic [RW-1:0] STB_LEN = RW'(ACC_CYC - 2);

   logic [RW-1:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else if (!ram_we_n || !ram_oe_n) run <= run + 1'b1;
      else run <= '0;
   end

   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_we_n && !ram_oe_n));
   assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_n && ram_oe_n && run != '0) |-> (run == STB_LEN));
   assert_strobe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_we_n || !ram_oe_n) |-> !bus_ack_n);
   assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack_n |-> !bus_req_n);
   assert_float_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack_n |-> (!drv_addr_en && !drv_data_en));
   assert_float_before_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ack_n) |-> $past(!drv_addr_en));
   assert_addr_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ram_we_n) || $fell(ram_oe_n)) |-> ($past(drv_addr_en) && $stable(addr_q)));
   assert_release_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req_n) |-> $rose(bus_ack_n));
   assert_data_driven_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> drv_data_en);
endmodule

bind shram_bus_master shram_bus_master_chk #(.AW(AW), .ACC_CYC(ACC_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n),
   .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
   .drv_addr_en(drv_addr_en), .drv_data_en(drv_data_en),
   .addr_q(seq_addr)
);

// File: tb/shram_bus_master_tb.sv
module shram_bus_master_tb_top;
   localparam int AW = 16, DW = 16, DEPTH = 4, ACC = 4, SYNC = 2;
   localparam int STB = ACC - 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid, bus_req_n, bus_ack_n, ram_we_n, ram_oe_n;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] ram_addr;
   logic bus_gnt_n = 1'b1;
   wire  [DW-1:0] ram_data;

   always #2.5 clk = ~clk;

   shram_bus_master #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ACC_CYC(ACC), .GNT_SYNC(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .bus_req_n(bus_req_n),
      .bus_gnt_n(bus_gnt_n), .bus_ack_n(bus_ack_n), .ram_addr(ram_addr),
      .ram_data(ram_data), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
   );

   int checks = 0, errors = 0;
   int cyc = 0, gnt_cyc = 0;
   logic force_off = 1'b0;
   logic [15:0] mem [64];
   logic [15:0] exp_mem [64];
   logic [32:0] op_q [$];
   logic [15:0] rd_q [$];

   function automatic logic [15:0] init_word(int i);
      return 16'((i * 16'h0123) ^ 16'h5A5A);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   assign ram_data = !ram_oe_n ? mem[ram_addr[5:0]] : {DW{1'bz}};

   always @(posedge clk) cyc <= cyc + 1;

   // host: grants after a random delay, drops the grant when the request ends
   initial begin
      int dly = 0, lim = 0;
      forever begin
         @(posedge clk); #2;
         if (force_off) bus_gnt_n = 1'b1;
         else if (bus_req_n) begin bus_gnt_n = 1'b1; dly = 0; lim = $urandom % 5; end
         else if (bus_gnt_n) begin
            if (dly >= lim) begin bus_gnt_n = 1'b0; gnt_cyc = cyc; end
            else dly++;
         end
      end
   end

   // monitor
   logic prev_stb = 1'b0, prev_ack = 1'b1, prev_req = 1'b1, prev_we = 1'b1, prev_oe = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   int we_run = 0, oe_run = 0;
   always @(negedge clk) if (rst_n) begin
      logic stb;
      stb = !ram_we_n || !ram_oe_n;
      if (!ram_we_n) mem[ram_addr[5:0]] = ram_data;
      if (stb && !prev_stb) begin
         check(!bus_ack_n, "R4", "strobe outside ack", bus_ack_n, 0);
         check(op_q.size() != 0, "R2", "unexpected access", op_q.size(), 1);
         if (op_q.size() != 0) begin
            logic [32:0] op;
            op = op_q.pop_front();
            check(ram_addr == op[31:16], "R2", "access address order", ram_addr, op[31:16]);
            check(prev_addr == op[31:16], "R6", "address setup", prev_addr, op[31:16]);
            check(!ram_we_n == op[32], "R5", "strobe kind we", !ram_we_n, op[32]);
            if (op[32]) check(ram_data == op[15:0], "R11", "write data", ram_data, op[15:0]);
         end
      end
      if (!ram_we_n) we_run++;
      else if (!prev_we) begin check(we_run == STB, "R5", "we width", we_run, STB); we_run = 0; end
      if (!ram_oe_n) oe_run++;
      else if (!prev_oe) begin check(oe_run == STB, "R5", "oe width", oe_run, STB); oe_run = 0; end
      if (!bus_ack_n && prev_ack)
         check(cyc - gnt_cyc == SYNC + 1 && !bus_gnt_n, "R10", "grant to ack latency",
               cyc - gnt_cyc, SYNC + 1);
      if (bus_req_n && !prev_req)
         check(bus_ack_n && !prev_ack, "R8", "req and ack release together", bus_ack_n, 1);
      if (rd_valid) begin
         check(rd_q.size() != 0, "R7", "spurious read result", rd_q.size(), 1);
         if (rd_q.size() != 0) begin
            logic [15:0] e;
            e = rd_q.pop_front();
            check(rd_data == e, "R7", "read data", rd_data, e);
         end
      end
      prev_stb = stb; prev_ack = bus_ack_n; prev_req = bus_req_n;
      prev_we = ram_we_n; prev_oe = ram_oe_n; prev_addr = ram_addr;
   end

   task automatic push_op(input logic w, input logic [15:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      do @(negedge clk); while (!req_ready);
      @(posedge clk);
      op_q.push_back({w, a, d});
      if (w) exp_mem[a[5:0]] = d;
      else   rd_q.push_back(exp_mem[a[5:0]]);
      #1 req_valid = 1'b0;
   endtask

   task automatic drain();
      do @(negedge clk);
      while (op_q.size() != 0 || rd_q.size() != 0 || !bus_ack_n || !bus_req_n);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED));
      for (int i = 0; i < 64; i++) begin mem[i] = init_word(i); exp_mem[i] = init_word(i); end
      repeat (4) @(negedge clk);
      check(bus_req_n && bus_ack_n && ram_we_n && ram_oe_n && !rd_valid && req_ready,
            "R1", "reset outputs", {bus_req_n, bus_ack_n, ram_we_n, ram_oe_n, rd_valid, req_ready}, 6'b111101);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(bus_req_n && bus_ack_n && ram_we_n && ram_oe_n && req_ready, "R1", "after reset",
            {bus_req_n, bus_ack_n, ram_we_n, ram_oe_n, req_ready}, 5'b11111);

      // R2/R3: fill the queue with no grant available
      force_off = 1'b1;
      for (int i = 0; i < DEPTH; i++) push_op(1'b1, 16'(i + 1), 16'hA000 + 16'(i));
      repeat (6) @(negedge clk);
      check(!req_ready, "R2", "ready low when full", req_ready, 0);
      check(!bus_req_n, "R3", "request while pending", bus_req_n, 0);
      check(bus_ack_n, "R3", "no ack without grant", bus_ack_n, 1);
      @(posedge clk); #1 force_off = 1'b0;
      push_op(1'b0, 16'h0003, 16'h0);
      push_op(1'b0, 16'h0001, 16'h0);
      drain();

      // random mix
      for (int n = 0; n < 250; n++) begin
         push_op(1'($urandom % 2), 16'($urandom), 16'($urandom));
         if ($urandom % 8 == 0) repeat ($urandom % 12) @(posedge clk);
      end
      drain();

      // R9: withdraw grant during a write strobe
      force_off = 1'b1;
      for (int i = 0; i < DEPTH; i++) push_op(1'b1, 16'h0020 + 16'(i), 16'hC0DE ^ 16'(i));
      @(posedge clk); #1 force_off = 1'b0;
      do @(negedge clk); while (ram_we_n);
      @(posedge clk); #1 force_off = 1'b1;
      begin
         int n = 0;
         do begin @(negedge clk); n++; end while (!bus_ack_n && n < 40);
         check(n <= SYNC + ACC + 3, "R9", "release after withdrawal", n, SYNC + ACC + 3);
         repeat (2) @(negedge clk);
         check(!bus_req_n && bus_ack_n, "R9", "re-request remaining work", bus_req_n, 0);
      end
      repeat (5) @(negedge clk);
      check(bus_ack_n && ram_we_n, "R9", "no access while grant withdrawn", bus_ack_n, 1);
      @(posedge clk); #1 force_off = 1'b0;
      for (int i = 0; i < DEPTH; i++) push_op(1'b0, 16'h0020 + 16'(i), 16'h0);
      drain();

      // R11: final RAM image
      begin
         int bad = 0;
         for (int i = 0; i < 64; i++) if (mem[i] != exp_mem[i]) bad++;
         check(bad == 0, "R11", "ram image mismatches", bad, 0);
      end
      check(op_q.size() == 0 && rd_q.size() == 0, "R7", "all results returned", rd_q.size(), 0);
      finish_run();
   end
endmodule